// File: doc/BRIEF.md
# Processor Idle and Wake Controller

This block decides when a processor core stops its clock and when it starts it again. A single control register selects how wake events are qualified and which clocks are gated while the core is idle. Software asks for idle through a request line. The controller then gates the core clock, and the timer clock if that is configured. It can deepen into a chip-level idle state when the bus-interface clock is set up for it.

Wake events can be qualified by an external active-low wake pin, which is synchronized inside the block. An interrupt ends core idle, and any wake source also ends chip idle. The controller also asks the PLL to idle, but only when the whole system is quiet: the DSP is in global idle, the core is idle, DMA is stopped or held off by the test-clock enable, no posted write is pending, and the peripheral clocks are off. All outputs are registered and change one clock after the decision that drives them.

Top module: `cpu_idle_ctl`

## Requirements
- R1: The control register at address 0x4 holds four read/write bits: bit 10 is wake-any, bit 9 is timer-idle, bit 8 is bus-interface-idle and bit 7 is PLL-enable. Read data for the address on `bus_addr` appears on `bus_rdata` one clock later.
- R2: After a synchronous reset the control register reads 0x400. `core_clk_en` and `tmr_clk_en` are 1, and `idle_flag`, `chip_idle_flag` and `pll_idle_req` are 0.
- R3: Writing the other bits of the control register has no effect, and they read as 0. Writes to address 0x8 are ignored.
- R4: With wake-any at 0, an interrupt ends idle only while the synchronized wake pin is low. The pin passes through two flops, so a low level ends idle on the third clock after it is applied.
- R5: With wake-any at 1, an interrupt ends idle whatever level the wake pin has.
- R6: From core idle the block moves to chip idle one clock later, while bus-interface-idle is 1 and `bif_clk_en_in` is 1. It falls back to core idle when either of these drops.
- R7: Wake sources end chip idle under the same pin qualification as the interrupt. In core idle they have no effect.
- R8: `tmr_clk_en` is 0 while the core is idle and timer-idle is 1. Otherwise it is 1.
- R9: With bus-interface-idle at 0, `bif_clk_en` follows `bif_clk_en_in`. With it at 1, `bif_clk_en` follows `bif_clk_req`. Either way the output lags the input by one clock.
- R10: `pll_idle_req` is 1 only when all of these hold: PLL-enable is 1, `dsp_gidle` is 1, the core is idle, `dma_busy` is 0 or `test_clk_en` is 0, `posted_wr_pend` is 0, and `periph_clk_off` is 1.
- R11: On the clock after a qualified wake, `core_clk_en` returns to 1 and `pll_idle_req` drops to 0 in the same cycle.
- R12: An idle request made while a qualified interrupt is present is ignored, and the core stays running.
- R13: The read-only register at address 0x8 gives the idle flag in bit 0 and the chip-idle flag in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| idle_req | input | 1 | Request for core idle |
| irq | input | 1 | Interrupt line |
| ext_wake_n | input | 1 | External wake pin, active low, asynchronous |
| wake_src | input | NUM_WAKE | Other wake sources |
| dsp_gidle | input | 1 | DSP is in global idle |
| dma_busy | input | 1 | A DMA transfer is active |
| test_clk_en | input | 1 | Test-clock enable pin; a low level masks DMA activity |
| posted_wr_pend | input | 1 | A posted write is queued |
| periph_clk_off | input | 1 | Peripheral clocks are stopped |
| bif_clk_en_in | input | 1 | Separate bus-interface clock enable |
| bif_clk_req | input | 1 | Bus-interface clock is needed |
| core_clk_en | output | 1 | Core clock enable |
| tmr_clk_en | output | 1 | Timer clock enable |
| bif_clk_en | output | 1 | Bus-interface clock enable |
| pll_idle_req | output | 1 | Request to idle the PLL |
| idle_flag | output | 1 | Core is idle |
| chip_idle_flag | output | 1 | Chip idle state is active |

## Verification
The assertions assume that a control-register write and a wake event may arrive in the same cycle, and that the FSM and the checker both judge that cycle by the register value from before the write. The checker therefore reads the synchronized pin and the stored wake-any bit rather than the raw pin. The stimulus drives every input just after a falling edge and holds it for whole cycles. It changes the wake pin only while the result can be observed three clocks later. It also drops `idle_req` and `irq` after each use, so no idle entry or exit overlaps the next step.

// File: rtl/idle_ctl_pkg.sv
package idle_ctl_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_CORE = 2'd1,
    ST_CHIP = 2'd2
  } idle_st_e;

  localparam int BIT_WAKE_ANY = 10;
  localparam int BIT_TMR_IDLE = 9;
  localparam int BIT_BIF_IDLE = 8;
  localparam int BIT_PLL_EN   = 7;

  typedef struct packed {
    logic wake_any;
    logic tmr_idle;
    logic bif_idle;
    logic pll_en;
  } idle_cfg_t;
endpackage

// File: rtl/idle_ctl_regs.sv
module idle_ctl_regs
  import idle_ctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CFG_OFF  = 4,
  parameter logic [ADDR_W-1:0] STAT_OFF = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              stat_idle,
  input  logic              stat_chip,
  output idle_cfg_t         cfg,
  output logic [DATA_W-1:0] rdata
);
  logic unused_wdata;
  assign unused_wdata = ^{wdata[DATA_W-1:BIT_WAKE_ANY+1], wdata[BIT_PLL_EN-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '{wake_any: 1'b1, tmr_idle: 1'b0, bif_idle: 1'b0, pll_en: 1'b0};
    end else if (wr && addr == CFG_OFF) begin
      cfg.wake_any <= wdata[BIT_WAKE_ANY];
      cfg.tmr_idle <= wdata[BIT_TMR_IDLE];
      cfg.bif_idle <= wdata[BIT_BIF_IDLE];
      cfg.pll_en   <= wdata[BIT_PLL_EN];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      if (addr == CFG_OFF) begin
        rdata[BIT_WAKE_ANY] <= cfg.wake_any;
        rdata[BIT_TMR_IDLE] <= cfg.tmr_idle;
        rdata[BIT_BIF_IDLE] <= cfg.bif_idle;
        rdata[BIT_PLL_EN]   <= cfg.pll_en;
      end else if (addr == STAT_OFF) begin
        rdata[1:0] <= {stat_chip, stat_idle};
      end
    end
  end
endmodule

// File: rtl/idle_ctl_sync.sv
module idle_ctl_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) chain[i] <= rst ? RST_VAL : d;
    end else begin : g_next
      always_ff @(posedge clk) chain[i] <= rst ? RST_VAL : chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/idle_ctl_fsm.sv
module idle_ctl_fsm
  import idle_ctl_pkg::*;
#(
  parameter int NUM_WAKE = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  idle_cfg_t           cfg,
  input  logic                wake_n_s,
  input  logic                idle_req,
  input  logic                irq,
  input  logic [NUM_WAKE-1:0] wake_src,
  input  logic                dsp_gidle,
  input  logic                dma_busy,
  input  logic                test_clk_en,
  input  logic                posted_wr_pend,
  input  logic                periph_clk_off,
  input  logic                bif_clk_en_in,
  input  logic                bif_clk_req,
  output logic                core_clk_en,
  output logic                tmr_clk_en,
  output logic                bif_clk_en,
  output logic                pll_idle_req,
  output logic                idle_flag,
  output logic                chip_idle_flag
);
  idle_st_e st, nxt;
  logic qual, irq_w, src_w, chip_ok, nxt_idle, quiet;

  always_comb begin
    qual     = cfg.wake_any | ~wake_n_s;
    irq_w    = irq & qual;
    src_w    = (|wake_src) & qual;
    chip_ok  = cfg.bif_idle & bif_clk_en_in;
    nxt      = st;
    case (st)
      ST_RUN:  if (idle_req && !irq_w) nxt = ST_CORE;
      ST_CORE: if (irq_w) nxt = ST_RUN;
               else if (chip_ok) nxt = ST_CHIP;
      ST_CHIP: if (irq_w || src_w) nxt = ST_RUN;
               else if (!chip_ok) nxt = ST_CORE;
      default: nxt = ST_RUN;
    endcase
    nxt_idle = (nxt != ST_RUN);
    quiet    = dsp_gidle & (~dma_busy | ~test_clk_en) & ~posted_wr_pend & periph_clk_off;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_RUN;
      core_clk_en    <= 1'b1;
      tmr_clk_en     <= 1'b1;
      bif_clk_en     <= 1'b0;
      pll_idle_req   <= 1'b0;
      idle_flag      <= 1'b0;
      chip_idle_flag <= 1'b0;
    end else begin
      st             <= nxt;
      core_clk_en    <= ~nxt_idle;
      tmr_clk_en     <= ~(nxt_idle & cfg.tmr_idle);
      bif_clk_en     <= cfg.bif_idle ? bif_clk_req : bif_clk_en_in;
      pll_idle_req   <= cfg.pll_en & nxt_idle & quiet;
      idle_flag      <= nxt_idle;
      chip_idle_flag <= (nxt == ST_CHIP);
    end
  end
endmodule

// File: rtl/cpu_idle_ctl.sv
module cpu_idle_ctl
  import idle_ctl_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int NUM_WAKE    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                idle_req,
  input  logic                irq,
  input  logic                ext_wake_n,
  input  logic [NUM_WAKE-1:0] wake_src,
  input  logic                dsp_gidle,
  input  logic                dma_busy,
  input  logic                test_clk_en,
  input  logic                posted_wr_pend,
  input  logic                periph_clk_off,
  input  logic                bif_clk_en_in,
  input  logic                bif_clk_req,
  output logic                core_clk_en,
  output logic                tmr_clk_en,
  output logic                bif_clk_en,
  output logic                pll_idle_req,
  output logic                idle_flag,
  output logic                chip_idle_flag
);
  localparam logic [ADDR_W-1:0] CFG_OFF  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STAT_OFF = ADDR_W'(8);

  idle_cfg_t cfg_q;
  logic      wake_n_sync;
  logic      cfg_wake_mode;

  assign cfg_wake_mode = cfg_q.wake_any;

  idle_ctl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_OFF(CFG_OFF), .STAT_OFF(STAT_OFF)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .stat_idle(idle_flag), .stat_chip(chip_idle_flag),
    .cfg(cfg_q), .rdata(bus_rdata)
  );

  idle_ctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(ext_wake_n), .q(wake_n_sync)
  );

  idle_ctl_fsm #(.NUM_WAKE(NUM_WAKE)) u_fsm (
    .clk(clk), .rst(rst), .cfg(cfg_q), .wake_n_s(wake_n_sync),
    .idle_req(idle_req), .irq(irq), .wake_src(wake_src),
    .dsp_gidle(dsp_gidle), .dma_busy(dma_busy), .test_clk_en(test_clk_en),
    .posted_wr_pend(posted_wr_pend), .periph_clk_off(periph_clk_off),
    .bif_clk_en_in(bif_clk_en_in), .bif_clk_req(bif_clk_req),
    .core_clk_en(core_clk_en), .tmr_clk_en(tmr_clk_en), .bif_clk_en(bif_clk_en),
    .pll_idle_req(pll_idle_req), .idle_flag(idle_flag), .chip_idle_flag(chip_idle_flag)
  );
endmodule

// File: rtl/cpu_idle_ctl_chk.sv
module cpu_idle_ctl_chk (
  input logic clk,
  input logic rst,
  input logic idle_req,
  input logic core_clk_en,
  input logic tmr_clk_en,
  input logic pll_idle_req,
  input logic idle_flag,
  input logic chip_idle_flag,
  input logic cfg_wake_mode,
  input logic wake_n_sync
);
  a_r2_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (core_clk_en && tmr_clk_en && !idle_flag && !pll_idle_req));

  a_r4_pin_gates_wake: assert property (@(posedge clk) disable iff (rst)
    (idle_flag && !cfg_wake_mode && wake_n_sync) |=> idle_flag);

  a_r6_chip_inside_idle: assert property (@(posedge clk) disable iff (rst)
    chip_idle_flag |-> idle_flag);

  a_r8_timer_runs_with_core: assert property (@(posedge clk) disable iff (rst)
    core_clk_en |-> tmr_clk_en);

  a_r10_pll_needs_idle: assert property (@(posedge clk) disable iff (rst)
    pll_idle_req |-> idle_flag);

  a_r11_exit_drops_pll: assert property (@(posedge clk) disable iff (rst)
    $fell(idle_flag) |-> (core_clk_en && !pll_idle_req));

  a_r12_entry_needs_request: assert property (@(posedge clk) disable iff (rst)
    $rose(idle_flag) |-> $past(idle_req));
endmodule

bind cpu_idle_ctl cpu_idle_ctl_chk u_chk (
  .clk(clk), .rst(rst), .idle_req(idle_req), .core_clk_en(core_clk_en),
  .tmr_clk_en(tmr_clk_en), .pll_idle_req(pll_idle_req), .idle_flag(idle_flag),
  .chip_idle_flag(chip_idle_flag), .cfg_wake_mode(cfg_wake_mode),
  .wake_n_sync(wake_n_sync)
);

// File: tb/cpu_idle_ctl_bench.sv
module cpu_idle_ctl_bench;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int NUM_WAKE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = 4'h4;
  logic bus_wr = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic idle_req = 1'b0, irq = 1'b0, ext_wake_n = 1'b1;
  logic [NUM_WAKE-1:0] wake_src = '0;
  logic dsp_gidle = 1'b0, dma_busy = 1'b0, test_clk_en = 1'b1, posted_wr_pend = 1'b0;
  logic periph_clk_off = 1'b0, bif_clk_en_in = 1'b1, bif_clk_req = 1'b0;
  logic core_clk_en, tmr_clk_en, bif_clk_en, pll_idle_req, idle_flag, chip_idle_flag;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  cpu_idle_ctl u_cpu_idle_ctl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .idle_req(idle_req), .irq(irq), .ext_wake_n(ext_wake_n),
    .wake_src(wake_src), .dsp_gidle(dsp_gidle), .dma_busy(dma_busy),
    .test_clk_en(test_clk_en), .posted_wr_pend(posted_wr_pend),
    .periph_clk_off(periph_clk_off), .bif_clk_en_in(bif_clk_en_in),
    .bif_clk_req(bif_clk_req), .core_clk_en(core_clk_en), .tmr_clk_en(tmr_clk_en),
    .bif_clk_en(bif_clk_en), .pll_idle_req(pll_idle_req), .idle_flag(idle_flag),
    .chip_idle_flag(chip_idle_flag)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    step(1);
    d = bus_rdata;
  endtask

  task automatic go_idle();
    idle_req = 1'b1;
    step(1);
    idle_req = 1'b0;
  endtask

  task automatic wake_irq();
    irq = 1'b1;
    step(1);
    irq = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] rv;
    step(3);
    rst = 1'b0;
    step(1);
    // R2 reset state
    chk("R2 cfg", bus_rdata, 32'h400);
    chk("R2 outs", {core_clk_en, tmr_clk_en, idle_flag, chip_idle_flag, pll_idle_req}, 5'b11000);

    // R1 / R3 read-write bits and reserved bits
    wr_reg(4'h4, 32'hFFFF_FFFF);
    rd_reg(4'h4, rv); chk("R3 reserved", rv, 32'h780);
    wr_reg(4'h4, 32'h0000_0180);
    rd_reg(4'h4, rv); chk("R1 readback", rv, 32'h180);
    wr_reg(4'h8, 32'hFFFF_FFFF);
    rd_reg(4'h8, rv); chk("R3 status ignores write", rv, 32'h0);
    rd_reg(4'h4, rv); chk("R3 cfg kept", rv, 32'h180);

    // R5 wake-any: irq exits regardless of pin (pin high)
    wr_reg(4'h4, 32'h400);
    go_idle();
    chk("R5 entered", {idle_flag, core_clk_en}, 2'b10);
    rd_reg(4'h8, rv); chk("R13 status idle", rv, 32'h1);
    wake_irq();
    chk("R5 irq exit", {idle_flag, core_clk_en}, 2'b01);

    // R12 request ignored with qualified irq present
    irq = 1'b1; idle_req = 1'b1;
    step(1);
    chk("R12 ignored", idle_flag, 1'b0);
    step(1);
    chk("R12 still running", core_clk_en, 1'b1);
    irq = 1'b0; idle_req = 1'b0;

    // R8 timer clock idle bit
    wr_reg(4'h4, 32'h600);
    go_idle();
    chk("R8 tmr stops", {tmr_clk_en, core_clk_en}, 2'b00);
    wake_irq();
    chk("R8 tmr back", tmr_clk_en, 1'b1);
    wr_reg(4'h4, 32'h400);
    go_idle();
    chk("R8 tmr keeps running", {tmr_clk_en, core_clk_en}, 2'b10);

    // R7 wake source ignored in core idle
    wake_src = 4'b0100;
    step(2);
    chk("R7 core idle ignores source", idle_flag, 1'b1);
    wake_src = '0;
    wake_irq();
    chk("R7 exit by irq", idle_flag, 1'b0);

    // R9 bus-interface clock
    bif_clk_en_in = 1'b0; step(1);
    chk("R9 follows enable low", bif_clk_en, 1'b0);
    bif_clk_en_in = 1'b1; step(1);
    chk("R9 follows enable high", bif_clk_en, 1'b1);
    wr_reg(4'h4, 32'h500);
    bif_clk_req = 1'b0; step(1);
    chk("R9 follows request low", bif_clk_en, 1'b0);
    bif_clk_req = 1'b1; step(1);
    chk("R9 follows request high", bif_clk_en, 1'b1);
    bif_clk_req = 1'b0;

    // R6 chip idle entry, fallback, and R7 wake source exit
    go_idle();
    chk("R6 core first", {idle_flag, chip_idle_flag}, 2'b10);
    step(1);
    chk("R6 chip idle", chip_idle_flag, 1'b1);
    rd_reg(4'h8, rv); chk("R13 status chip", rv, 32'h3);
    bif_clk_en_in = 1'b0; step(1);
    chk("R6 fallback", {idle_flag, chip_idle_flag}, 2'b10);
    bif_clk_en_in = 1'b1; step(1);
    chk("R6 re-enter", chip_idle_flag, 1'b1);
    wake_src = 4'b0001; step(1);
    chk("R7 source ends chip idle", {idle_flag, chip_idle_flag, core_clk_en}, 3'b001);
    wake_src = '0;

    // R7 with pin qualification in mode 0
    wr_reg(4'h4, 32'h100);
    go_idle(); step(1);
    chk("R7 chip mode0", chip_idle_flag, 1'b1);
    wake_src = 4'b1000; step(2);
    chk("R7 pin high blocks source", chip_idle_flag, 1'b1);
    ext_wake_n = 1'b0; step(3);
    chk("R7 pin low passes source", idle_flag, 1'b0);
    wake_src = '0; ext_wake_n = 1'b1; step(3);

    // R4 mode 0 with pin qualification and sync depth
    wr_reg(4'h4, 32'h000);
    go_idle();
    irq = 1'b1; step(3);
    chk("R4 pin high blocks irq", idle_flag, 1'b1);
    ext_wake_n = 1'b0; step(2);
    chk("R4 two flop delay", idle_flag, 1'b1);
    step(1);
    chk("R4 pin low passes irq", {idle_flag, core_clk_en}, 2'b01);
    irq = 1'b0; ext_wake_n = 1'b1; step(3);

    // R10 exhaustive PLL condition sweep while idle (mode 0, pin high)
    chk("R10 not idle", pll_idle_req, 1'b0);
    go_idle();
    for (int i = 0; i < 64; i++) begin
      logic b7, e;
      b7 = i[0];
      wr_reg(4'h4, b7 ? 32'h080 : 32'h000);
      dsp_gidle = i[1]; dma_busy = i[2]; test_clk_en = i[3];
      posted_wr_pend = i[4]; periph_clk_off = i[5];
      step(1);
      e = b7 & i[1] & (~i[2] | ~i[3]) & ~i[4] & i[5];
      chk("R10 sweep", pll_idle_req, e);
    end

    // R11 exit timing
    wr_reg(4'h4, 32'h080);
    dsp_gidle = 1'b1; dma_busy = 1'b1; test_clk_en = 1'b0;
    posted_wr_pend = 1'b0; periph_clk_off = 1'b1;
    step(1);
    chk("R11 pll raised", pll_idle_req, 1'b1);
    irq = 1'b1; ext_wake_n = 1'b0; step(2);
    chk("R11 still idle", {pll_idle_req, core_clk_en}, 2'b10);
    step(1);
    chk("R11 exit same cycle", {pll_idle_req, core_clk_en, idle_flag}, 3'b010);
    irq = 1'b0; ext_wake_n = 1'b1;
    step(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule